// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two bidirectional data buses, called side A and side B. Each side has a storage register with its own capture clock. On a rising edge of that clock, the register takes whatever value is present on its side's bus. On the selected side, the block drives either live data taken from the opposite bus or the word held in the opposite side's register. One part can therefore pass data through, capture it on either side, or replay a stored word.

Each bus is modelled as three signals: a separate input vector, an output vector and an output enable. The enclosing pad or bus logic resolves them. An active-low enable and a direction input decide which side, if either, is driven. All selection and enable paths are combinational, so they take effect without a clock edge. Only the two registers hold state.

Top module: `reg_xcvr`

## Requirements
- R1: On each rising edge of `clk_a` with `rst` low, the A register loads the A-bus value. That value is `a_out` while `a_oe` is 1, and `a_in` otherwise.
- R2: On each rising edge of `clk_b` with `rst` low, the B register loads the B-bus value. That value is `b_out` while `b_oe` is 1, and `b_in` otherwise.
- R3: Reset is synchronous and active high. A rising edge of `clk_a` with `rst` high clears the A register to all zeros. A rising edge of `clk_b` with `rst` high clears the B register to all zeros.
- R4: While `en_n` is 1, `a_oe` and `b_oe` are both 0, and `a_out` and `b_out` are both all zeros.
- R5: While `en_n` is 0 and `dir` is 1, `b_oe` is 1 and `a_oe` is 0.
- R6: While `en_n` is 0 and `dir` is 0, `a_oe` is 1 and `b_oe` is 0.
- R7: While `b_oe` is 1, `b_out` depends on `sel_ab`. When `sel_ab` is 0, `b_out` equals `a_in`. When `sel_ab` is 1, `b_out` equals the A register.
- R8: While `a_oe` is 1, `a_out` depends on `sel_ba`. When `sel_ba` is 0, `a_out` equals `b_in`. When `sel_ba` is 1, `a_out` equals the B register.
- R9: A change on `en_n`, `dir`, `sel_ab`, `sel_ba`, `a_in` or `b_in` reaches the outputs with no clock edge in between.
- R10: A register clocked while the block drives its own bus captures the driven word. For example, the A register loads `a_out` while `a_oe` is 1.
- R11: Both registers still capture while `en_n` is 1, with both outputs disabled.
- R12: `a_oe` and `b_oe` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Capture clock of the A register |
| clk_b | input | 1 | Capture clock of the B register |
| rst | input | 1 | Synchronous active-high clear, sampled by each register on its own clock |
| en_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: drive side B; 0: drive side A |
| sel_ab | input | 1 | Source for side B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for side A: 0 live B, 1 stored B |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Word driven onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Word driven onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The only state is the two registers. A wrong stored word stays hidden until the register is selected for replay. When `sel_ab` or `sel_ba` is 1 and the matching side is driven, a wrong value appears on that bus in the same cycle. For this reason the bench follows every capture with a sweep that includes the stored-source modes. A capture with the wrong source, such as taking the pin input instead of the driven word, shows only on the next replay after that clock edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Source selection: 0 picks the live word, 1 picks the stored word
  function automatic logic [63:0] pick_src(input logic [63:0] live,
                                           input logic [63:0] held,
                                           input logic use_held);
    return use_held ? held : live;
  endfunction

  // Value present on a bus: the block's own drive wins over the pin input
  function automatic logic [63:0] bus_value(input logic [63:0] pin,
                                            input logic [63:0] drv,
                                            input logic drv_en);
    return drv_en ? drv : pin;
  endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic seen;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  always_ff @(posedge clk) seen <= 1'b1;

  AST_CLEAR_ON_RESET: assert property (@(posedge clk)
    seen && $past(rst) |-> q == '0);  // R3

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive (
  input  logic en_n,
  input  logic dir,
  output logic oe_a,
  output logic oe_b
);

  always_comb begin
    oe_a = 1'b0;
    oe_b = 1'b0;
    if (!en_n) begin
      if (dir) oe_b = 1'b1;
      else     oe_a = 1'b1;
    end
  end

  always_comb begin
    AST_SINGLE_DRIVER: assert (!(oe_a && oe_b));  // R12
  end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int W = 8
) (
  input  logic         oe,
  input  logic         use_held,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] drv
);
  import xcvr_pkg::*;

  localparam int PADW = 64 - W;

  logic [63:0] chosen;

  always_comb begin
    chosen = pick_src({{PADW{1'b0}}, live}, {{PADW{1'b0}}, held}, use_held);
    drv    = oe ? chosen[W-1:0] : '0;
  end

endmodule

// File: rtl/reg_xcvr.sv
module reg_xcvr #(
  parameter int W = 8
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst,
  input  logic         en_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  import xcvr_pkg::*;

  localparam int PADW = 64 - W;

  // Named internal events for the assertions
  logic [W-1:0] a_q, b_q;
  logic [W-1:0] a_bus, b_bus;
  logic [63:0]  a_bus_w, b_bus_w;
  logic         seen_a, seen_b;

  xcvr_drive u_drive (
    .en_n (en_n),
    .dir  (dir),
    .oe_a (a_oe),
    .oe_b (b_oe)
  );

  // Only one side is ever driven, so the live source of each path is the
  // opposite pin input; this keeps the paths free of combinational loops.
  xcvr_path #(.W(W)) u_to_b (
    .oe       (b_oe),
    .use_held (sel_ab),
    .live     (a_in),
    .held     (a_q),
    .drv      (b_out)
  );

  xcvr_path #(.W(W)) u_to_a (
    .oe       (a_oe),
    .use_held (sel_ba),
    .live     (b_in),
    .held     (b_q),
    .drv      (a_out)
  );

  always_comb begin
    a_bus_w = bus_value({{PADW{1'b0}}, a_in}, {{PADW{1'b0}}, a_out}, a_oe);
    b_bus_w = bus_value({{PADW{1'b0}}, b_in}, {{PADW{1'b0}}, b_out}, b_oe);
    a_bus   = a_bus_w[W-1:0];
    b_bus   = b_bus_w[W-1:0];
  end

  xcvr_store #(.W(W)) u_store_a (
    .clk (clk_a),
    .rst (rst),
    .d   (a_bus),
    .q   (a_q)
  );

  xcvr_store #(.W(W)) u_store_b (
    .clk (clk_b),
    .rst (rst),
    .d   (b_bus),
    .q   (b_q)
  );

  always_ff @(posedge clk_a) seen_a <= 1'b1;
  always_ff @(posedge clk_b) seen_b <= 1'b1;

  AST_CAPTURE_A: assert property (@(posedge clk_a) disable iff (rst)
    seen_a && !$past(rst) |-> a_q == $past(a_oe ? a_out : a_in));  // R1
  AST_CAPTURE_B: assert property (@(posedge clk_b) disable iff (rst)
    seen_b && !$past(rst) |-> b_q == $past(b_oe ? b_out : b_in));  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_a)
    en_n |-> !a_oe && !b_oe && a_out == '0 && b_out == '0);  // R4
  AST_DRIVE_B: assert property (@(posedge clk_a)
    !en_n && dir |-> b_oe && !a_oe);  // R5
  AST_DRIVE_A: assert property (@(posedge clk_a)
    !en_n && !dir |-> a_oe && !b_oe);  // R6
  AST_REPLAY_A2B: assert property (@(posedge clk_b) disable iff (rst)
    seen_a && b_oe && sel_ab |-> b_out == a_q);  // R7
  AST_REPLAY_B2A: assert property (@(posedge clk_a) disable iff (rst)
    seen_b && a_oe && sel_ba |-> a_out == b_q);  // R8

endmodule

// File: tb/sim_reg_xcvr.sv
module sim_reg_xcvr;
  localparam int W = 8;
  localparam int CLK_P = 10;

  logic clk_a = 0, clk_b = 0, rst = 1;
  logic en_n = 1, dir = 0, sel_ab = 0, sel_ba = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int total = 0, bad = 0;
  int ra = 0, rb = 0;  // reference copies of both registers
  bit done = 0;

  reg_xcvr #(.W(W)) u0 (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_aoe(); return (!en_n && !dir) ? 1 : 0; endfunction
  function automatic int exp_boe(); return (!en_n && dir) ? 1 : 0; endfunction
  function automatic int exp_aout();
    if (exp_aoe() == 0) return 0;
    return sel_ba ? rb : int'(b_in);
  endfunction
  function automatic int exp_bout();
    if (exp_boe() == 0) return 0;
    return sel_ab ? ra : int'(a_in);
  endfunction

  task automatic compare(input string req);
    string oreq;
    oreq = en_n ? "R4" : (dir ? "R5" : "R6");
    chk(oreq, "a_oe", int'(a_oe), exp_aoe());
    chk(oreq, "b_oe", int'(b_oe), exp_boe());
    chk("R12", "both_oe", int'(a_oe & b_oe), 0);
    chk(en_n ? "R4" : (req == "" ? "R8" : req), "a_out", int'(a_out), exp_aout());
    chk(en_n ? "R4" : (req == "" ? "R7" : req), "b_out", int'(b_out), exp_bout());
  endtask

  task automatic pulse(input bit da, input bit db);
    int na, nb;
    na = (exp_aoe() != 0) ? exp_aout() : int'(a_in);
    nb = (exp_boe() != 0) ? exp_bout() : int'(b_in);
    clk_a = da; clk_b = db;
    #(CLK_P/2);
    if (da) ra = rst ? 0 : na;
    if (db) rb = rst ? 0 : nb;
    clk_a = 0; clk_b = 0;
    #(CLK_P/2);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R3: reset clears both registers, seen through the replay paths
    a_in = 8'h5a; b_in = 8'ha5;
    #(CLK_P/2);
    pulse(1, 1); pulse(1, 1);
    rst = 0;
    en_n = 0; dir = 1; sel_ab = 1; #1;
    chk("R3", "b_out after reset", int'(b_out), 0);
    dir = 0; sel_ba = 1; #1;
    chk("R3", "a_out after reset", int'(a_out), 0);
    en_n = 1; #1;
    compare("");

    // Sweep every enable/direction/select combination under four clock patterns
    for (int rep = 0; rep < 6; rep++) begin
      for (int c = 0; c < 16; c++) begin
        {en_n, dir, sel_ab, sel_ba} = 4'(c);
        a_in = 8'($urandom); b_in = 8'($urandom);
        #1;
        compare("");
        case (rep % 4)
          1: pulse(1, 0);
          2: pulse(0, 1);
          3: pulse(1, 1);
          default: #(CLK_P);
        endcase
        #1;
        // R1/R2/R10/R11: the new register content shows on replay paths
        compare(en_n ? "R11" : (rep % 4 == 0 ? "" : "R10"));
      end
    end

    // R1: capture a known A word while disabled, then replay it onto B
    en_n = 1; a_in = 8'h3c; #1;
    pulse(1, 0);
    en_n = 0; dir = 1; sel_ab = 1; a_in = 8'h00; #1;
    chk("R1", "stored A replay", int'(b_out), 8'h3c);
    chk("R11", "capture while disabled", int'(b_out), ra);

    // R2: capture a known B word, replay onto A
    en_n = 1; b_in = 8'hc3; #1;
    pulse(0, 1);
    en_n = 0; dir = 0; sel_ba = 1; b_in = 8'h11; #1;
    chk("R2", "stored B replay", int'(a_out), 8'hc3);

    // R10: A driven from live B; clocking A stores the driven word, not a_in
    sel_ba = 0; b_in = 8'h77; a_in = 8'h22; #1;
    pulse(1, 0);
    dir = 1; sel_ab = 1; #1;
    chk("R10", "A captured driven word", int'(b_out), 8'h77);

    // R9: select and direction changes take effect with no clock
    sel_ab = 0; a_in = 8'h99; #1;
    chk("R9", "live after select flip", int'(b_out), 8'h99);
    sel_ab = 1; #1;
    chk("R9", "stored after select flip", int'(b_out), 8'h77);
    a_in = 8'h44; #1;
    chk("R9", "stored ignores a_in", int'(b_out), 8'h77);
    dir = 0; sel_ba = 0; b_in = 8'h0f; #1;
    chk("R9", "direction flip", int'(a_out), 8'h0f);
    chk("R6", "b_oe after flip", int'(b_oe), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule